// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmitter

This block shifts one byte at a time out of a serial data pin, timed by a shift clock that it either makes itself (master) or takes from the remote device (slave). Software runs it through a small register port. It sets the enables, the clocking mode, the bit order and the master clock divisor. It loads the byte and then writes a trigger bit. When the byte has gone out, a sticky done flag is raised, and an interrupt line follows that flag when the interrupt enable is set.

Data leaves on the falling edges of the shift clock, so the remote device samples on the rising edges. Between transfers the clock rests high and the data pin keeps the last bit sent. The register port has no back-pressure: a write is accepted in the cycle it is presented and a read returns combinationally. Software paces each byte with the done flag, and the trigger is the only start condition. Writing 0 to both enable bits returns the block to its idle state.

Register map: address 0 is control (bit0 transmit enable, bit1 receive enable, bit2 master, bit3 MSB first, bit4 interrupt enable). Address 1 is the data byte. Address 2 is command on write (bit0 trigger, bit1 clear done) and status on read (bit0 busy, bit1 done, bit2 data pending). Address 3 is the divisor DIV.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, status (address 2) reads 0, sout=1, sclk_o=1, sclk_oe=0 and irq=0.
- R2: A trigger (write to address 2 with bit0=1) starts a transfer only when control bit0 is 1, the data byte (address 1) has been written since the last start or idle reset, and no transfer is busy. In any other case busy stays 0 and sclk_o stays high.
- R3: In master mode (control bit2=1), sclk_oe=1. During a transfer sclk_o has exactly 8 low phases, each low and high phase lasting DIV+1 clock cycles, and it rests high afterwards.
- R4: sout takes the next bit at each falling edge of the shift clock. With control bit3=0 the k-th bit sent is data[k] (LSB first). With bit3=1 it is data[7-k] (MSB first).
- R5: After the last bit, sout keeps that level until a later transfer drives a new bit.
- R6: At the 8th rising shift-clock edge, busy (status bit0) clears and the done flag (status bit1) sets. irq equals the done flag ANDed with control bit4.
- R7: Writing address 2 with bit1=1 clears the done flag, and with it irq.
- R8: While busy, a trigger is ignored and a data write does not alter the byte in flight. Such a write sets status bit2, so the next trigger sends the new byte.
- R9: In slave mode (control bit2=0), sclk_oe=0. The byte shifts on falling edges of sclk_i after a SYNC_STAGES-cycle synchronizer, and completes at its 8th rising edge.
- R10: A control write with bit0 and bit1 both 0 aborts any transfer. It clears busy, done and pending, and returns sout and sclk_o to 1.
- R11: Reads of addresses 0, 1 and 3 return the control bits, the data byte and DIV as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Register read data, combinational |
| sclk_i | input | 1 | Shift clock from the remote device (slave mode) |
| sclk_o | output | 1 | Generated shift clock, idles high |
| sclk_oe | output | 1 | Shift clock pin drive enable, high in master mode |
| sout | output | 1 | Serial data out |
| irq | output | 1 | Transmit-done interrupt request |

## Verification
The hardest situation to reach is an abort or a repeated trigger that lands part-way through a byte. The port gives no direct view of how many bits have gone, so the bench watches sclk_o and acts on its own count of rising edges. It aborts after the third bit. In a second case it writes a new byte and a trigger while the first byte is still shifting, then checks that the first byte arrives intact and that the second goes out only on a later trigger. Around these cases, every data value is sent in both bit orders at the fastest divisor, and a set of values is sent at slower divisors and in slave mode.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_DATA = 2'd1,
    ADDR_CMD  = 2'd2,
    ADDR_DIV  = 2'd3
  } sst_addr_e;

  // packed: tx_en is bit 0, irq_en is bit 4
  typedef struct packed {
    logic irq_en;
    logic msb_first;
    logic master;
    logic rx_en;
    logic tx_en;
  } sst_ctrl_t;

  localparam int CTRL_W   = $bits(sst_ctrl_t);
  localparam int CMD_TRIG = 0;
  localparam int CMD_CLR  = 1;
  localparam int ST_BUSY  = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_PEND  = 2;
endpackage

// File: rtl/sst_regs.sv
module sst_regs
  import sst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 busy,
  input  logic                 done_evt,
  output sst_ctrl_t            ctrl,
  output logic [DATA_W-1:0]    data_q,
  output logic [DIV_W-1:0]     div_q,
  output logic                 start,
  output logic                 if_rst,
  output logic                 done_flag
);
  logic pending_q;
  logic wr_ctrl, wr_dat, wr_cmd, wr_div;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_dat  = wr_en && (wr_addr == ADDR_DATA);
  assign wr_cmd  = wr_en && (wr_addr == ADDR_CMD);
  assign wr_div  = wr_en && (wr_addr == ADDR_DIV);

  // both enables low holds the interface idle
  assign if_rst = !ctrl.tx_en && !ctrl.rx_en;
  assign start  = wr_cmd && wr_data[CMD_TRIG] && ctrl.tx_en && pending_q && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      data_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl   <= sst_ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_dat)  data_q <= wr_data;
      if (wr_div)  div_q  <= wr_data[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      done_flag <= 1'b0;
    end else if (if_rst) begin
      pending_q <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (wr_dat)     pending_q <= 1'b1;
      else if (start) pending_q <= 1'b0;
      // completion wins over a simultaneous clear
      if (done_evt)                         done_flag <= 1'b1;
      else if (wr_cmd && wr_data[CMD_CLR])  done_flag <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (sst_addr_e'(rd_addr))
      ADDR_CTRL: rd_data[CTRL_W-1:0] = ctrl;
      ADDR_DATA: rd_data = data_q;
      ADDR_CMD: begin
        rd_data[ST_BUSY] = busy;
        rd_data[ST_DONE] = done_flag;
        rd_data[ST_PEND] = pending_q;
      end
      ADDR_DIV:  rd_data[DIV_W-1:0] = div_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sst_clkgen.sv
module sst_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             fall_p,
  output logic             rise_p
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick   = run && (cnt_q == '0);
  assign fall_p = tick && sclk;
  assign rise_p = tick && !sclk;

  // each phase lasts div+1 cycles; clock rests high when not running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sclk  <= 1'b1;
    end else if (!run) begin
      cnt_q <= div;
      sclk  <= 1'b1;
    end else if (tick) begin
      cnt_q <= div;
      sclk  <= ~sclk;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sst_slvsync.sv
module sst_slvsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sclk_i,
  output logic fall_p,
  output logic rise_p
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= sclk_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[STAGES-1];

  assign fall_p = en && prev_q && !sync_q[STAGES-1];
  assign rise_p = en && !prev_q && sync_q[STAGES-1];
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [DATA_W-1:0] data,
  input  logic              msb_first,
  input  logic              master_in,
  input  logic              fall_p,
  input  logic              rise_p,
  output logic              busy,
  output logic              master_q,
  output logic              sout,
  output logic              done_evt
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  bits_q;
  logic              msb_q;

  assign done_evt = busy && !abort && rise_p && (bits_q == CNT_W'(DATA_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      bits_q   <= '0;
      msb_q    <= 1'b0;
      master_q <= 1'b0;
      busy     <= 1'b0;
      sout     <= 1'b1;
    end else if (abort) begin
      bits_q <= '0;
      busy   <= 1'b0;
      sout   <= 1'b1;
    end else if (start) begin
      sh_q     <= data;
      bits_q   <= '0;
      msb_q    <= msb_first;
      master_q <= master_in;
      busy     <= 1'b1;
    end else if (busy) begin
      if (fall_p && bits_q < CNT_W'(DATA_W)) begin
        if (msb_q) begin
          sout <= sh_q[DATA_W-1];
          sh_q <= sh_q << 1;
        end else begin
          sout <= sh_q[0];
          sh_q <= sh_q >> 1;
        end
        bits_q <= bits_q + 1'b1;
      end
      if (done_evt) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              sout,
  output logic              irq
);
  sst_ctrl_t         ctrl;
  logic [DATA_W-1:0] data_q;
  logic [DIV_W-1:0]  div_q;
  logic start, if_rst, done_flag, done_evt, busy, master_q;
  logic m_fall, m_rise, s_fall, s_rise, fall_sel, rise_sel;

  sst_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done_evt(done_evt), .ctrl(ctrl), .data_q(data_q),
    .div_q(div_q), .start(start), .if_rst(if_rst), .done_flag(done_flag)
  );

  sst_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk(clk), .rst_n(rst_n), .run(busy && master_q && !if_rst),
    .div(div_q), .sclk(sclk_o), .fall_p(m_fall), .rise_p(m_rise)
  );

  sst_slvsync #(.STAGES(SYNC_STAGES)) i_slvsync (
    .clk(clk), .rst_n(rst_n), .en(busy && !master_q), .sclk_i(sclk_i),
    .fall_p(s_fall), .rise_p(s_rise)
  );

  assign fall_sel = master_q ? m_fall : s_fall;
  assign rise_sel = master_q ? m_rise : s_rise;

  sst_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(if_rst), .data(data_q),
    .msb_first(ctrl.msb_first), .master_in(ctrl.master),
    .fall_p(fall_sel), .rise_p(rise_sel), .busy(busy),
    .master_q(master_q), .sout(sout), .done_evt(done_evt)
  );

  assign sclk_oe = ctrl.master;
  assign irq     = done_flag && ctrl.irq_en;
endmodule

// File: rtl/sst_checker.sv
module sst_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sclk_o,
  input logic sout,
  input logic flag,
  input logic tx_en,
  input logic if_on,
  input logic shift_fall
);
  // R3: generated clock rests high outside a transfer
  a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_o);

  // R2: no transfer can begin while transmit is disabled
  a_r2_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tx_en) |=> !busy);

  // R4 / R5: data pin moves only on a shift-clock fall
  a_r4_sout_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!shift_fall) && $past(if_on)) |-> $stable(sout));

  // R6: normal end of a transfer raises the done flag
  a_r6_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(if_on)) |-> flag);

  // R10: idle reset clears transfer state and parks the pin high
  a_r10_idle_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !if_on |=> (!busy && sout && !flag));
endmodule

bind sync_ser_tx sst_checker i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sclk_o(sclk_o), .sout(sout),
  .flag(done_flag), .tx_en(ctrl.tx_en), .if_on(!if_rst), .shift_fall(fall_sel)
);

// File: tb/test_sync_ser_tx.sv
module test_sync_ser_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic sclk_i = 1'b1;
  logic sclk_o, sclk_oe, sout, irq;

  int vec = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  sync_ser_tx i_sync_ser_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sout(sout), .irq(irq)
  );

  // master-mode monitor on the generated clock
  logic       mon_on = 1'b0;
  logic       mon_prev = 1'b1;
  int         mon_cnt = 0;
  int         mon_err = 0;
  int         mon_half = 1;
  int         mon_fall_t = 0;
  int         mon_rise_t = 0;
  logic [7:0] mon_bits = '0;

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (mon_prev && !sclk_o) begin
        if (mon_cnt > 0 && (cyc - mon_rise_t) != mon_half) mon_err++;
        mon_fall_t = cyc;
      end
      if (!mon_prev && sclk_o) begin
        if ((cyc - mon_fall_t) != mon_half) mon_err++;
        if (mon_cnt < 8) mon_bits[mon_cnt] = sout;
        mon_cnt++;
        mon_rise_t = cyc;
      end
    end
    mon_prev = sclk_o;
  end

  task automatic chk(string tag, int act, int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [7:0] order(logic [7:0] d, logic msb);
    logic [7:0] s;
    for (int k = 0; k < 8; k++) s[k] = msb ? d[7-k] : d[k];
    return s;
  endfunction

  task automatic arm(int div);
    mon_cnt = 0; mon_err = 0; mon_half = div + 1; mon_bits = '0; mon_on = 1'b1;
  endtask

  task automatic wait_bits(int n);
    for (int g = 0; g < 4000 && mon_cnt < n; g++) @(negedge clk);
  endtask

  task automatic master_xfer(logic [7:0] d, logic msb, int div, logic ien);
    logic [7:0] st;
    wr(2'd0, {3'b000, ien, msb, 1'b1, 1'b0, 1'b1});
    wr(2'd3, 8'(div));
    wr(2'd1, d);
    arm(div);
    wr(2'd2, 8'h01);
    wait_bits(8);
    repeat (3) @(negedge clk);
    chk("R4 bit sequence", mon_bits, order(d, msb));
    chk("R3 phase length", mon_err, 0);
    chk("R3 low pulse count", mon_cnt, 8);
    chk("R3 drive enable", sclk_oe, 1);
    rd(2'd2, st);
    chk("R6 status after done", st, 8'h02);
    chk("R6 irq follows enable", irq, ien);
    repeat (4) @(negedge clk);
    chk("R5 last bit held", sout, msb ? d[0] : d[7]);
    chk("R3 clock rests high", sclk_o, 1);
    wr(2'd2, 8'h02);
    rd(2'd2, st);
    chk("R7 flag cleared", st, 8'h00);
    chk("R7 irq cleared", irq, 0);
    mon_on = 1'b0;
  endtask

  task automatic slave_xfer(logic [7:0] d, logic msb);
    logic [7:0] st;
    logic [7:0] exp;
    exp = order(d, msb);
    wr(2'd0, {4'b0000, msb, 1'b0, 1'b0, 1'b1});
    chk("R9 drive enable off", sclk_oe, 0);
    wr(2'd1, d);
    wr(2'd2, 8'h01);
    repeat (4) @(negedge clk);
    chk("R9 pin held before first edge", sclk_o, 1);
    for (int k = 0; k < 8; k++) begin
      sclk_i = 1'b0;
      repeat (6) @(negedge clk);
      chk("R9 slave bit", sout, exp[k]);
      sclk_i = 1'b1;
      repeat (6) @(negedge clk);
    end
    rd(2'd2, st);
    chk("R9 slave completion", st, 8'h02);
    wr(2'd2, 8'h02);
  endtask

  initial begin : watchdog
    wait (cyc > 190000);
    bad++;
    vec++;
    $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd2, st);
    chk("R1 status", st, 0);
    chk("R1 sout", sout, 1);
    chk("R1 sclk_o", sclk_o, 1);
    chk("R1 sclk_oe", sclk_oe, 0);
    chk("R1 irq", irq, 0);

    // R2 trigger while disabled, then without fresh data
    wr(2'd1, 8'h55);
    wr(2'd2, 8'h01);
    rd(2'd2, st);
    chk("R2 disabled trigger", st, 0);
    wr(2'd0, 8'h05);
    wr(2'd2, 8'h01);
    repeat (10) @(negedge clk);
    rd(2'd2, st);
    chk("R2 trigger without data", st, 0);
    chk("R2 clock stays high", sclk_o, 1);

    // R11 readback
    rd(2'd0, st); chk("R11 control readback", st, 8'h05);
    rd(2'd1, st); chk("R11 data readback", st, 8'h55);
    wr(2'd3, 8'h07);
    rd(2'd3, st); chk("R11 divisor readback", st, 8'h07);

    // full data sweep at the fastest divisor, both orders
    for (int v = 0; v < 256; v++) begin
      master_xfer(8'(v), 1'b0, 0, v[0]);
      master_xfer(8'(v), 1'b1, 0, v[1]);
    end

    // slower divisors
    for (int dv = 1; dv < 6; dv += 2)
      for (int i = 0; i < 6; i++) begin
        master_xfer(8'(i * 37 + 11), 1'(i), dv, 1'b1);
      end

    // R8 trigger and data write while busy
    wr(2'd0, 8'h05);
    wr(2'd3, 8'h03);
    wr(2'd1, 8'hA5);
    arm(3);
    wr(2'd2, 8'h01);
    wait_bits(2);
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'h01);
    rd(2'd2, st);
    chk("R8 busy with pending", st, 8'h05);
    wait_bits(8);
    repeat (3) @(negedge clk);
    chk("R8 byte in flight kept", mon_bits, 8'hA5);
    rd(2'd2, st);
    chk("R8 status after first", st, 8'h06);
    repeat (40) @(negedge clk);
    chk("R8 no extra start", mon_cnt, 8);
    wr(2'd2, 8'h02);
    arm(3);
    wr(2'd2, 8'h01);
    wait_bits(8);
    repeat (3) @(negedge clk);
    chk("R8 second byte sent", mon_bits, 8'h3C);
    wr(2'd2, 8'h02);

    // R10 abort mid-byte
    wr(2'd0, 8'h15);
    wr(2'd3, 8'h05);
    wr(2'd1, 8'hF0);
    arm(5);
    wr(2'd2, 8'h01);
    wait_bits(3);
    wr(2'd0, 8'h00);
    @(negedge clk);
    rd(2'd2, st);
    chk("R10 status cleared", st, 0);
    chk("R10 sout parked", sout, 1);
    chk("R10 clock parked", sclk_o, 1);
    repeat (30) @(negedge clk);
    chk("R10 no further edges", mon_cnt, 3);
    chk("R10 irq low", irq, 0);
    mon_on = 1'b0;

    // R9 slave mode
    for (int i = 0; i < 8; i++) slave_xfer(8'(i * 53 + 7), 1'(i));

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule